// File: doc/BRIEF.md
# Ring-Array Bearing Estimator (Four Elements, Shared CORDIC)

This block estimates the bearing of one narrowband source from a single snapshot of four complex baseband samples. The samples come from four antennas spaced evenly on a circle. Element i sits at angle 2πi/4 around the ring. For each element, the block multiplies its sample by the conjugate of its next neighbour's sample. The last element pairs with element 0. The phase of each of these four products is a pair phase difference. The four differences are folded into a sine term and a cosine term, and a four-quadrant arctangent of those two terms gives the bearing.

All five arctangents (four pair phases and the bearing) run on a single iterative CORDIC in vectoring mode, one after the other. A snapshot is offered with `in_valid`. It is taken only while `busy` is low. Each taken snapshot produces exactly one `out_valid` pulse, carrying the bearing and a flag that marks a degenerate snapshot. Angles are unsigned fractions of a full turn: 65536 units make 2π.

Top module: `doa_ring_estimator`

## Requirements
- R1: Pair product k is formed as real = ar·br + ai·bi and imag = ai·br − ar·bi, where a is element k and b is element (k+1) mod 4. The last pair wraps to element 0. Products are kept at full precision and arithmetically shifted right by 7 bits, giving 18 bits.
- R2: Each pair phase is the four-quadrant arctangent of its product, computed in 16-bit two's-complement turn units (65536 = 2π). The CORDIC runs 16 vectoring iterations after a half-turn pre-rotation of any vector with negative real part. Exactly four pair phases are written per snapshot.
- R3: The bearing is atan2(S, C) with S = φ1 + φ2 − φ0 − φ3 and C = φ0 + φ1 − φ2 − φ3. It is reported on `out_angle` as an unsigned 16-bit value in [0, 65536), 65536 being one full turn.
- R4: For a plane wave in which element i carries phase β·cos(θ − i·π/2) plus a common carrier phase, with β between 0.6 and 1.1 rad and amplitude of at least 1200 counts, `out_angle` is within 1 degree (182 units) of θ anywhere on the circle.
- R5: When S and C are both zero, `out_angle` is 0 and `out_invalid` is 1. Otherwise `out_invalid` is 0.
- R6: A snapshot is taken on a clock edge where `in_valid` is 1 and `busy` is 0. `in_valid` and the sample inputs have no effect while `busy` is 1.
- R7: Each taken snapshot raises `busy` and produces exactly one single-cycle `out_valid`. That pulse appears 5·(16+2) = 90 clock edges after the taking edge, and `busy` drops in the same cycle. `out_angle` and `out_invalid` hold their values between pulses.
- R8: After reset, `busy`, `out_valid`, `out_invalid` and `out_angle` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Snapshot offered this cycle |
| in_re | input | 48 | Real parts, element i at bits [12i+11:12i], signed |
| in_im | input | 48 | Imaginary parts, same packing, signed |
| busy | output | 1 | A snapshot is being processed; new ones are refused |
| out_valid | output | 1 | One-cycle pulse: bearing result ready |
| out_angle | output | 16 | Bearing, unsigned, 65536 units per turn |
| out_invalid | output | 1 | Degenerate snapshot (both folded terms zero) |

## Verification
Plane waves at bearings spread over all four quadrants, including just below a full turn, are each checked two ways. They are compared against a floating-point restatement of the pair-phase folding, which exposes a wrong conjugate side, a wrong wrap pair or a wrong sign in the sums. They are also compared against the true bearing, which exposes quantisation and CORDIC convergence loss. Randomised bearings, wave numbers, amplitudes and carrier phases show that the common carrier phase cancels. Snapshots where all elements are equal, or all zero, drive the degenerate path. A snapshot that keeps `in_valid` high with altered data while busy shows that the block takes no second snapshot and that the first result is undisturbed.

// File: rtl/doa_pkg.sv
package doa_pkg;

  localparam int ELEMS    = 4;
  localparam int EVALS    = ELEMS + 1;
  localparam int ANG_W    = 16;
  localparam int MAX_ITER = 16;

  typedef logic [ANG_W-1:0] turn_t;

  localparam turn_t HALF_TURN = {1'b1, {(ANG_W-1){1'b0}}};

  // arctan(2^-idx) expressed in turn units (65536 per full turn), rounded
  function automatic turn_t atan_step(input int idx);
    case (idx)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/doa_cmul.sv
module doa_cmul
  import doa_pkg::*;
#(
  parameter int W     = 12,
  parameter int OUT_W = 18
) (
  input  logic [ELEMS*W-1:0]        re_i,
  input  logic [ELEMS*W-1:0]        im_i,
  output logic signed [OUT_W-1:0]   pr_o [ELEMS],
  output logic signed [OUT_W-1:0]   pi_o [ELEMS]
);

  localparam int PROD_W = 2 * W;
  localparam int FULL_W = PROD_W + 1;
  localparam int SHIFT  = FULL_W - OUT_W;

  // full-precision a * conj(b): real part
  function automatic logic signed [FULL_W-1:0] conj_re(
    input logic signed [W-1:0] ar, input logic signed [W-1:0] ai,
    input logic signed [W-1:0] br, input logic signed [W-1:0] bi);
    logic signed [PROD_W-1:0] p_rr, p_ii;
    p_rr = PROD_W'(ar) * PROD_W'(br);
    p_ii = PROD_W'(ai) * PROD_W'(bi);
    return FULL_W'(p_rr) + FULL_W'(p_ii);
  endfunction

  // full-precision a * conj(b): imaginary part
  function automatic logic signed [FULL_W-1:0] conj_im(
    input logic signed [W-1:0] ar, input logic signed [W-1:0] ai,
    input logic signed [W-1:0] br, input logic signed [W-1:0] bi);
    logic signed [PROD_W-1:0] p_ir, p_ri;
    p_ir = PROD_W'(ai) * PROD_W'(br);
    p_ri = PROD_W'(ar) * PROD_W'(bi);
    return FULL_W'(p_ir) - FULL_W'(p_ri);
  endfunction

  function automatic logic signed [OUT_W-1:0] narrow(input logic signed [FULL_W-1:0] v);
    return OUT_W'(v >>> SHIFT);
  endfunction

  for (genvar k = 0; k < ELEMS; k++) begin : g_pair
    localparam int NB = (k + 1) % ELEMS;
    logic signed [W-1:0] a_re, a_im, b_re, b_im;
    assign a_re = signed'(re_i[k*W +: W]);
    assign a_im = signed'(im_i[k*W +: W]);
    assign b_re = signed'(re_i[NB*W +: W]);
    assign b_im = signed'(im_i[NB*W +: W]);
    assign pr_o[k] = narrow(conj_re(a_re, a_im, b_re, b_im));
    assign pi_o[k] = narrow(conj_im(a_re, a_im, b_re, b_im));
  end

endmodule

// File: rtl/doa_cordic_vec.sv
module doa_cordic_vec
  import doa_pkg::*;
#(
  parameter int IN_W = 18,
  parameter int ITER = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  output logic                   done_o,
  output turn_t                  z_o
);

  localparam int XW    = IN_W + 2;
  localparam int CNT_W = $clog2(ITER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER);

  logic signed [XW-1:0] x_q, y_q;
  turn_t                z_q;
  logic                 run_q;
  logic [CNT_W-1:0]     cnt_q;

  logic signed [XW-1:0] x_ld, y_ld, x_sh, y_sh;
  turn_t                z_ld, step;
  logic                 rot_up;

  // left half-plane vectors are turned by half a turn before iterating
  always_comb begin
    x_ld = XW'(x_i);
    y_ld = XW'(y_i);
    z_ld = '0;
    if (x_i[IN_W-1]) begin
      x_ld = -x_ld;
      y_ld = -y_ld;
      z_ld = HALF_TURN;
    end
  end

  assign x_sh   = x_q >>> cnt_q;
  assign y_sh   = y_q >>> cnt_q;
  assign step   = atan_step(int'(cnt_q));
  assign rot_up = y_q[XW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      x_q   <= x_ld;
      y_q   <= y_ld;
      z_q   <= z_ld;
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && cnt_q != LAST) begin
      if (rot_up) begin
        x_q <= x_q - y_sh;
        y_q <= y_q + x_sh;
        z_q <= z_q - step;
      end else begin
        x_q <= x_q + y_sh;
        y_q <= y_q - x_sh;
        z_q <= z_q + step;
      end
      cnt_q <= cnt_q + 1'b1;
    end else if (run_q) begin
      run_q <= 1'b0;
    end
  end

  assign done_o = run_q && (cnt_q == LAST);
  assign z_o    = z_q;

endmodule

// File: rtl/doa_seq.sv
module doa_seq
  import doa_pkg::*;
#(
  parameter int IN_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take_i,
  input  logic signed [IN_W-1:0] pair_re_i [ELEMS],
  input  logic signed [IN_W-1:0] pair_im_i [ELEMS],
  input  logic                   cdone_i,
  input  turn_t                  cz_i,
  output logic                   busy_o,
  output logic                   cstart_o,
  output logic signed [IN_W-1:0] op_x_o,
  output logic signed [IN_W-1:0] op_y_o,
  output logic                   phase_wr_o,
  output logic                   out_valid_o,
  output turn_t                  angle_o,
  output logic                   invalid_o
);

  localparam int SEL_W = $clog2(EVALS);
  localparam int IDX_W = $clog2(ELEMS);
  localparam logic [SEL_W-1:0] FINAL_SEL = SEL_W'(ELEMS);

  typedef enum logic [1:0] {ST_IDLE, ST_KICK, ST_WAIT} seq_state_e;

  seq_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  turn_t            phase_q [ELEMS];

  logic signed [IN_W-1:0] sin_term, cos_term;
  logic                   degenerate, final_done;

  function automatic logic signed [IN_W-1:0] widen(input turn_t p);
    return IN_W'(signed'(p));
  endfunction

  // folded sine term: pairs 1,2 minus pairs 0,3
  function automatic logic signed [IN_W-1:0] fold_sin(
    input turn_t p0, input turn_t p1, input turn_t p2, input turn_t p3);
    return widen(p1) + widen(p2) - widen(p0) - widen(p3);
  endfunction

  // folded cosine term: pairs 0,1 minus pairs 2,3
  function automatic logic signed [IN_W-1:0] fold_cos(
    input turn_t p0, input turn_t p1, input turn_t p2, input turn_t p3);
    return widen(p0) + widen(p1) - widen(p2) - widen(p3);
  endfunction

  assign sin_term   = fold_sin(phase_q[0], phase_q[1], phase_q[2], phase_q[3]);
  assign cos_term   = fold_cos(phase_q[0], phase_q[1], phase_q[2], phase_q[3]);
  assign degenerate = (sin_term == '0) && (cos_term == '0);

  always_comb begin
    if (sel_q == FINAL_SEL) begin
      op_x_o = cos_term;
      op_y_o = sin_term;
    end else begin
      op_x_o = pair_re_i[sel_q[IDX_W-1:0]];
      op_y_o = pair_im_i[sel_q[IDX_W-1:0]];
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cstart_o   = (state_q == ST_KICK);
  assign phase_wr_o = (state_q == ST_WAIT) && cdone_i && (sel_q != FINAL_SEL);
  assign final_done = (state_q == ST_WAIT) && cdone_i && (sel_q == FINAL_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sel_q       <= '0;
      out_valid_o <= 1'b0;
      angle_o     <= '0;
      invalid_o   <= 1'b0;
      for (int k = 0; k < ELEMS; k++) phase_q[k] <= '0;
    end else begin
      out_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take_i) begin
            sel_q   <= '0;
            state_q <= ST_KICK;
          end
        end
        ST_KICK: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (phase_wr_o) begin
            phase_q[sel_q[IDX_W-1:0]] <= cz_i;
            sel_q   <= sel_q + 1'b1;
            state_q <= ST_KICK;
          end else if (final_done) begin
            angle_o     <= degenerate ? '0 : cz_i;
            invalid_o   <= degenerate;
            out_valid_o <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/doa_ring_estimator.sv
module doa_ring_estimator
  import doa_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ITER  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ELEMS*SMP_W-1:0]   in_re,
  input  logic [ELEMS*SMP_W-1:0]   in_im,
  output logic                     busy,
  output logic                     out_valid,
  output logic [ANG_W-1:0]         out_angle,
  output logic                     out_invalid
);

  localparam int CORD_W = ANG_W + 2;

  // named internal events, observed by the bound checker
  logic accept;
  logic cordic_start;
  logic cordic_done;
  logic phase_wr;

  logic [ELEMS*SMP_W-1:0]   re_q, im_q;
  logic signed [CORD_W-1:0] pair_re [ELEMS];
  logic signed [CORD_W-1:0] pair_im [ELEMS];
  logic signed [CORD_W-1:0] op_x, op_y;
  turn_t                    cordic_z;
  turn_t                    angle_w;

  assign accept = in_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= '0;
      im_q <= '0;
    end else if (accept) begin
      re_q <= in_re;
      im_q <= in_im;
    end
  end

  doa_cmul #(.W(SMP_W), .OUT_W(CORD_W)) u_cmul (
    .re_i (re_q),
    .im_i (im_q),
    .pr_o (pair_re),
    .pi_o (pair_im)
  );

  doa_seq #(.IN_W(CORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (accept),
    .pair_re_i   (pair_re),
    .pair_im_i   (pair_im),
    .cdone_i     (cordic_done),
    .cz_i        (cordic_z),
    .busy_o      (busy),
    .cstart_o    (cordic_start),
    .op_x_o      (op_x),
    .op_y_o      (op_y),
    .phase_wr_o  (phase_wr),
    .out_valid_o (out_valid),
    .angle_o     (angle_w),
    .invalid_o   (out_invalid)
  );

  doa_cordic_vec #(.IN_W(CORD_W), .ITER(ITER)) u_cordic (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cordic_start),
    .x_i     (op_x),
    .y_i     (op_y),
    .done_o  (cordic_done),
    .z_o     (cordic_z)
  );

  assign out_angle = angle_w;

endmodule

// File: rtl/doa_ring_estimator_chk.sv
module doa_ring_estimator_chk
  import doa_pkg::*;
#(
  parameter int ITER = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             busy,
  input logic             out_valid,
  input logic [ANG_W-1:0] out_angle,
  input logic             out_invalid,
  input logic             accept,
  input logic             phase_wr
);

  localparam int LAT   = EVALS * (ITER + 2);
  localparam int CNT_W = $clog2(LAT + 2);
  localparam int WR_W  = $clog2(ELEMS + 1) + 1;

  logic [CNT_W-1:0] busy_cnt;
  logic [WR_W-1:0]  wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_cnt <= '0;
    else if (accept)   wr_cnt <= '0;
    else if (phase_wr) wr_cnt <= wr_cnt + 1'b1;
  end

  assert_pair_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wr_cnt == WR_W'(ELEMS));

  assert_zero_on_degenerate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_angle == '0);

  assert_take_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_busy_from_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_pulse_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!busy && $past(busy)));

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy_cnt == CNT_W'(LAT));

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < CNT_W'(LAT));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_angle) && $stable(out_invalid)));

endmodule

bind doa_ring_estimator doa_ring_estimator_chk #(.ITER(ITER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .busy        (busy),
  .out_valid   (out_valid),
  .out_angle   (out_angle),
  .out_invalid (out_invalid),
  .accept      (accept),
  .phase_wr    (phase_wr)
);

// File: tb/doa_ring_estimator_tb_top.sv
module doa_ring_estimator_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  SMP_W      = 12;
  localparam int  ITER       = 16;
  localparam int  NEL        = 4;
  localparam int  LATENCY    = 5 * (ITER + 2);
  localparam int  MODEL_TOL  = 48;
  localparam int  TRUTH_TOL  = 182;
  localparam int  WATCHDOG   = 150000;
  localparam real PI         = 3.14159265358979;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [NEL*SMP_W-1:0] in_re = '0;
  logic [NEL*SMP_W-1:0] in_im = '0;
  logic                 busy, out_valid, out_invalid;
  logic [15:0]          out_angle;

  int checks = 0, failures = 0, cycles = 0, pulses = 0;
  int cur_re [NEL];
  int cur_im [NEL];

  doa_ring_estimator #(.SMP_W(SMP_W), .ITER(ITER)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .busy(busy), .out_valid(out_valid), .out_angle(out_angle), .out_invalid(out_invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (out_valid) pulses++;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic int cdiff(input int got, input int exp);
    int d;
    d = (got - exp) % 65536;
    if (d < 0) d += 65536;
    if (d >= 32768) d -= 65536;
    return d;
  endfunction

  // plane wave: element i carries beta*cos(theta - i*pi/2) on top of a common carrier phase
  task automatic build_wave(input real theta, input real beta, input real amp, input real carrier);
    for (int i = 0; i < NEL; i++) begin
      real ph;
      ph = carrier + beta * $cos(theta - PI * i / 2.0);
      cur_re[i] = rnd(amp * $cos(ph));
      cur_im[i] = rnd(amp * $sin(ph));
    end
  endtask

  // bench restatement of the pair products, phase folding and final angle, in turn units
  function automatic int model_angle();
    real ph [NEL];
    real s_t, c_t, a;
    for (int i = 0; i < NEL; i++) begin
      int  j;
      real pr, pim;
      j   = (i + 1) % NEL;
      pr  = real'(cur_re[i]) * real'(cur_re[j]) + real'(cur_im[i]) * real'(cur_im[j]);
      pim = real'(cur_im[i]) * real'(cur_re[j]) - real'(cur_re[i]) * real'(cur_im[j]);
      ph[i] = $atan2(pim, pr);
    end
    s_t = ph[1] + ph[2] - ph[0] - ph[3];
    c_t = ph[0] + ph[1] - ph[2] - ph[3];
    a = $atan2(s_t, c_t);
    if (a < 0.0) a += 2.0 * PI;
    return rnd(a * 65536.0 / (2.0 * PI)) % 65536;
  endfunction

  task automatic run_snap(input bit disturb, output int lat, output int ang,
                          output bit inv, output int npulse);
    int p0;
    @(negedge clk);
    for (int i = 0; i < NEL; i++) begin
      in_re[i*SMP_W +: SMP_W] = cur_re[i][SMP_W-1:0];
      in_im[i*SMP_W +: SMP_W] = cur_im[i][SMP_W-1:0];
    end
    in_valid = 1'b1;
    p0 = pulses;
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      in_re = ~in_re;
      in_im = in_im ^ {NEL{12'h5A3}};
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_valid && lat < 400) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    ang = int'(out_angle);
    inv = out_invalid;
    repeat (3) @(negedge clk);
    npulse = pulses - p0;
  endtask

  task automatic wave_test(input real deg, input real beta, input real amp,
                           input real carrier, input bit disturb);
    int lat, ang, np, exp_m, exp_t;
    bit inv;
    build_wave(deg * PI / 180.0, beta, amp, carrier);
    exp_m = model_angle();
    exp_t = rnd(deg * 65536.0 / 360.0) % 65536;
    run_snap(disturb, lat, ang, inv, np);
    check(lat == LATENCY, "R7", "result latency", lat, LATENCY);
    check(np == 1, disturb ? "R6" : "R7", "result pulses per snapshot", np, 1);
    check(inv == 1'b0, "R5", "invalid flag on regular wave", inv, 0);
    // wrap pairing, conjugate side, pair phases and folding
    check(cdiff(ang, exp_m) <= MODEL_TOL && cdiff(ang, exp_m) >= -MODEL_TOL,
          "R1 R2 R3", "angle vs folded-phase model", ang, exp_m);
    check(cdiff(ang, exp_t) <= TRUTH_TOL && cdiff(ang, exp_t) >= -TRUTH_TOL,
          disturb ? "R6" : "R4", "angle vs true bearing", ang, exp_t);
    if (disturb) check(busy == 1'b0, "R6", "no second snapshot taken", busy, 0);
  endtask

  initial begin
    int lat, ang, np;
    bit inv;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(busy == 1'b0,        "R8", "busy after reset", busy, 0);
    check(out_valid == 1'b0,   "R8", "out_valid after reset", out_valid, 0);
    check(out_angle == 16'd0,  "R8", "angle after reset", out_angle, 0);
    check(out_invalid == 1'b0, "R8", "invalid after reset", out_invalid, 0);

    // directed bearings in every quadrant and at the wrap
    wave_test(0.0,    0.9, 1800.0, 0.3, 1'b0);
    wave_test(45.0,   0.9, 1800.0, 1.1, 1'b0);
    wave_test(90.0,   1.0, 1600.0, 2.5, 1'b0);
    wave_test(135.0,  0.7, 1900.0, 4.0, 1'b0);
    wave_test(180.0,  0.9, 1500.0, 5.5, 1'b0);
    wave_test(270.0,  1.1, 1300.0, 0.0, 1'b0);
    wave_test(315.0,  0.6, 2000.0, 3.3, 1'b0);
    wave_test(359.9,  0.9, 1800.0, 0.8, 1'b0);

    // randomised plane waves
    for (int n = 0; n < 40; n++) begin
      real deg, beta, amp, car;
      deg  = real'($urandom_range(0, 35999)) / 100.0;
      beta = 0.6 + real'($urandom_range(0, 500)) / 1000.0;
      amp  = 1200.0 + real'($urandom_range(0, 700));
      car  = real'($urandom_range(0, 6283)) / 1000.0;
      wave_test(deg, beta, amp, car, 1'b0);
    end

    // R6: in_valid held with altered data during processing
    wave_test(200.0, 0.9, 1700.0, 1.7, 1'b1);

    // R5: all elements identical, then all zero
    for (int i = 0; i < NEL; i++) begin cur_re[i] = 700; cur_im[i] = -300; end
    run_snap(1'b0, lat, ang, inv, np);
    check(inv == 1'b1,  "R5", "invalid on equal elements", inv, 1);
    check(ang == 0,     "R5", "angle on equal elements", ang, 0);
    check(np == 1,      "R7", "pulse on equal elements", np, 1);
    for (int i = 0; i < NEL; i++) begin cur_re[i] = 0; cur_im[i] = 0; end
    run_snap(1'b0, lat, ang, inv, np);
    check(inv == 1'b1,  "R5", "invalid on zero input", inv, 1);
    check(ang == 0,     "R5", "angle on zero input", ang, 0);
    check(lat == LATENCY, "R7", "latency on zero input", lat, LATENCY);

    // R5: flag clears again on a regular wave
    wave_test(30.0, 0.9, 1800.0, 2.0, 1'b0);

    report();
    $finish;
  end

endmodule